// File: doc/BRIEF.md
# Single-Level Shadow Register Bank

This block is a one-deep save store that sits beside a small processor register file. It keeps two independent save sets. The working set holds the first four working registers together with five arithmetic status flags. It is filled by an explicit save command and read back by an explicit restore command. The loop set holds the hardware loop's first-address, last-address and iteration-count registers. It is filled when a loop begins and read back when the loop finishes.

The host drives its current register values and the four command strobes. When a restore command arrives, the block returns the saved contents on registered restore buses the following cycle, together with a single-cycle valid strobe for that set. The host then writes those values back into its registers. The saved copies cannot be read or written in any other way. Each set keeps only one level, so a second save replaces the first.

The restored status word carries the saved values only in the five flag positions. Every other status bit is passed through from the live status word that the host presents in the restore cycle. This lets the host write the whole word back without disturbing bits that were never saved.

Top module: `shadow_bank`

## Requirements
- R1: After reset, restoreWValid and restoreLoopValid are 0, and every restore data output is 0.
- R2: A cycle with saveWork high captures hostW (W0 in bits [15:0] up to W3 in bits [63:48]). A cycle with restoreWork high presents the saved words on restoreW in the next cycle. Asserting saveWork and restoreWork together is a usage error.
- R3: On a work restore, restoreStatus bits 0 (carry), 1 (zero), 2 (overflow), 3 (negative) and 8 (digit carry) take their saved values. All other bits equal hostStatus as sampled in the restore-command cycle.
- R4: A cycle with loopBegin high captures hostLoopStart, hostLoopEnd and hostLoopCount. A cycle with loopFinish high presents them on the restoreLoop outputs in the next cycle.
- R5: Each set is one level deep: a second save before a restore overwrites the earlier contents.
- R6: A restore with no save since reset returns zero in every saved field, and no other reaction.
- R7: The two sets are independent. A command to one set never changes the other set's saved contents or outputs, and commands to both sets may fall in the same cycle.
- R8: Each valid strobe is high in exactly the cycle after its restore command. Restore data outputs hold their last values between restores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| saveWork | input | 1 | Save working registers and flags |
| restoreWork | input | 1 | Restore working registers and flags |
| loopBegin | input | 1 | Hardware loop start event (save loop set) |
| loopFinish | input | 1 | Hardware loop end event (restore loop set) |
| hostW | input | 64 | Live W0..W3, W0 in the low word |
| hostStatus | input | 16 | Live status word |
| hostLoopStart | input | 24 | Live loop first address |
| hostLoopEnd | input | 24 | Live loop last address |
| hostLoopCount | input | 14 | Live loop iteration count |
| restoreW | output | 64 | Restored W0..W3 |
| restoreStatus | output | 16 | Restored status word (merged) |
| restoreWValid | output | 1 | One-cycle strobe for the working set |
| restoreLoopStart | output | 24 | Restored loop first address |
| restoreLoopEnd | output | 24 | Restored loop last address |
| restoreLoopCount | output | 14 | Restored loop count |
| restoreLoopValid | output | 1 | One-cycle strobe for the loop set |

## Verification
Operations on the working set and the loop set can fall in the same cycle. Examples are a loop start together with a work restore, or a loop end together with a work save. The bench provokes these crossings in directed steps and then through many random cycles that draw each strobe independently. Pops of the same set are dropped whenever a save is drawn. After every clock edge, a bench model of both sets predicts every restore output and valid strobe. Any movement of the untouched set's outputs or strobe is reported.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;

  // Strobes handed from the control section to the datapath
  typedef struct packed {
    logic captureWork;
    logic returnWork;
    logic captureLoop;
    logic returnLoop;
  } shadowCtrl_t;

  localparam int unsigned DefDataW  = 16;
  localparam int unsigned DefNumW   = 4;
  localparam int unsigned DefStatW  = 16;
  localparam int unsigned DefAddrW  = 24;
  localparam int unsigned DefCntW   = 14;
  // carry, zero, overflow, negative, digit carry
  localparam logic [15:0] DefFlagMask = 16'h010F;

endpackage

// File: rtl/shadow_bank_ctrl.sv
module shadow_bank_ctrl
  import shadow_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        saveWork,
  input  logic        restoreWork,
  input  logic        loopBegin,
  input  logic        loopFinish,
  output shadowCtrl_t ctrl,
  output logic        workValid,
  output logic        loopValid
);

  always_comb begin
    ctrl.captureWork = saveWork;
    ctrl.returnWork  = restoreWork;
    ctrl.captureLoop = loopBegin;
    ctrl.returnLoop  = loopFinish;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workValid <= 1'b0;
      loopValid <= 1'b0;
    end else begin
      workValid <= ctrl.returnWork;
      loopValid <= ctrl.returnLoop;
    end
  end

endmodule

// File: rtl/shadow_bank_dp.sv
module shadow_bank_dp
  import shadow_bank_pkg::*;
#(
  parameter int unsigned DATA_W = DefDataW,
  parameter int unsigned NUM_W  = DefNumW,
  parameter int unsigned STAT_W = DefStatW,
  parameter int unsigned ADDR_W = DefAddrW,
  parameter int unsigned CNT_W  = DefCntW,
  parameter logic [STAT_W-1:0] FLAG_MASK = STAT_W'(DefFlagMask)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  shadowCtrl_t             ctrl,
  input  logic [NUM_W*DATA_W-1:0] hostW,
  input  logic [STAT_W-1:0]       hostStatus,
  input  logic [ADDR_W-1:0]       hostLoopStart,
  input  logic [ADDR_W-1:0]       hostLoopEnd,
  input  logic [CNT_W-1:0]        hostLoopCount,
  output logic [NUM_W*DATA_W-1:0] restoreW,
  output logic [STAT_W-1:0]       restoreStatus,
  output logic [ADDR_W-1:0]       restoreLoopStart,
  output logic [ADDR_W-1:0]       restoreLoopEnd,
  output logic [CNT_W-1:0]        restoreLoopCount
);

  localparam int unsigned WorkW = NUM_W * DATA_W;

  logic [WorkW-1:0]  shadowW;
  logic [STAT_W-1:0] shadowFlags;
  logic [ADDR_W-1:0] shadowStart;
  logic [ADDR_W-1:0] shadowEnd;
  logic [CNT_W-1:0]  shadowCount;

  // one shadow word per working register
  for (genvar gw = 0; gw < NUM_W; gw++) begin : g_wordShadow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowW[gw*DATA_W +: DATA_W] <= '0;
      end else if (ctrl.captureWork) begin
        shadowW[gw*DATA_W +: DATA_W] <= hostW[gw*DATA_W +: DATA_W];
      end
    end
  end

  // flops only for the flag positions that are saved
  for (genvar gb = 0; gb < STAT_W; gb++) begin : g_flagShadow
    if (FLAG_MASK[gb]) begin : g_kept
      always_ff @(posedge clk) begin
        if (!rstN) begin
          shadowFlags[gb] <= 1'b0;
        end else if (ctrl.captureWork) begin
          shadowFlags[gb] <= hostStatus[gb];
        end
      end
    end else begin : g_dropped
      assign shadowFlags[gb] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowStart <= '0;
      shadowEnd   <= '0;
      shadowCount <= '0;
    end else if (ctrl.captureLoop) begin
      shadowStart <= hostLoopStart;
      shadowEnd   <= hostLoopEnd;
      shadowCount <= hostLoopCount;
    end
  end

  logic [STAT_W-1:0] mergedStatus;
  always_comb begin
    mergedStatus = (hostStatus & ~FLAG_MASK) | (shadowFlags & FLAG_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      restoreW      <= '0;
      restoreStatus <= '0;
    end else if (ctrl.returnWork) begin
      restoreW      <= shadowW;
      restoreStatus <= mergedStatus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      restoreLoopStart <= '0;
      restoreLoopEnd   <= '0;
      restoreLoopCount <= '0;
    end else if (ctrl.returnLoop) begin
      restoreLoopStart <= shadowStart;
      restoreLoopEnd   <= shadowEnd;
      restoreLoopCount <= shadowCount;
    end
  end

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int unsigned DATA_W = DefDataW,
  parameter int unsigned NUM_W  = DefNumW,
  parameter int unsigned STAT_W = DefStatW,
  parameter int unsigned ADDR_W = DefAddrW,
  parameter int unsigned CNT_W  = DefCntW,
  parameter logic [STAT_W-1:0] FLAG_MASK = STAT_W'(DefFlagMask)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    saveWork,
  input  logic                    restoreWork,
  input  logic                    loopBegin,
  input  logic                    loopFinish,
  input  logic [NUM_W*DATA_W-1:0] hostW,
  input  logic [STAT_W-1:0]       hostStatus,
  input  logic [ADDR_W-1:0]       hostLoopStart,
  input  logic [ADDR_W-1:0]       hostLoopEnd,
  input  logic [CNT_W-1:0]        hostLoopCount,
  output logic [NUM_W*DATA_W-1:0] restoreW,
  output logic [STAT_W-1:0]       restoreStatus,
  output logic                    restoreWValid,
  output logic [ADDR_W-1:0]       restoreLoopStart,
  output logic [ADDR_W-1:0]       restoreLoopEnd,
  output logic [CNT_W-1:0]        restoreLoopCount,
  output logic                    restoreLoopValid
);

  shadowCtrl_t ctrl;

  shadow_bank_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .saveWork    (saveWork),
    .restoreWork (restoreWork),
    .loopBegin   (loopBegin),
    .loopFinish  (loopFinish),
    .ctrl        (ctrl),
    .workValid   (restoreWValid),
    .loopValid   (restoreLoopValid)
  );

  shadow_bank_dp #(
    .DATA_W    (DATA_W),
    .NUM_W     (NUM_W),
    .STAT_W    (STAT_W),
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .FLAG_MASK (FLAG_MASK)
  ) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .ctrl             (ctrl),
    .hostW            (hostW),
    .hostStatus       (hostStatus),
    .hostLoopStart    (hostLoopStart),
    .hostLoopEnd      (hostLoopEnd),
    .hostLoopCount    (hostLoopCount),
    .restoreW         (restoreW),
    .restoreStatus    (restoreStatus),
    .restoreLoopStart (restoreLoopStart),
    .restoreLoopEnd   (restoreLoopEnd),
    .restoreLoopCount (restoreLoopCount)
  );

endmodule

// File: rtl/shadow_bank_checker.sv
module shadow_bank_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_W  = 4,
  parameter int unsigned STAT_W = 16,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 14,
  parameter logic [STAT_W-1:0] FLAG_MASK = '0
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    saveWork,
  input logic                    restoreWork,
  input logic                    loopBegin,
  input logic                    loopFinish,
  input logic [NUM_W*DATA_W-1:0] hostW,
  input logic [STAT_W-1:0]       hostStatus,
  input logic [ADDR_W-1:0]       hostLoopStart,
  input logic [ADDR_W-1:0]       hostLoopEnd,
  input logic [CNT_W-1:0]        hostLoopCount,
  input logic [NUM_W*DATA_W-1:0] restoreW,
  input logic [STAT_W-1:0]       restoreStatus,
  input logic                    restoreWValid,
  input logic [ADDR_W-1:0]       restoreLoopStart,
  input logic [ADDR_W-1:0]       restoreLoopEnd,
  input logic [CNT_W-1:0]        restoreLoopCount,
  input logic                    restoreLoopValid
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!restoreWValid && !restoreLoopValid && restoreW == '0 && restoreLoopCount == '0));

  assert_no_work_clash_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(saveWork && restoreWork));

  assert_save_then_restore_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(saveWork) && restoreWork) |=> (restoreW == $past(hostW, 2)));

  assert_passthrough_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    restoreWork |=> ((restoreStatus & ~FLAG_MASK) == ($past(hostStatus) & ~FLAG_MASK)));

  assert_no_loop_clash_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(loopBegin && loopFinish));

  assert_loop_save_restore_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(loopBegin) && loopFinish) |=>
      (restoreLoopStart == $past(hostLoopStart, 2) && restoreLoopEnd == $past(hostLoopEnd, 2)
       && restoreLoopCount == $past(hostLoopCount, 2)));

  assert_loop_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !loopFinish |=> ($stable(restoreLoopStart) && $stable(restoreLoopEnd) && $stable(restoreLoopCount)));

  assert_work_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !restoreWork |=> ($stable(restoreW) && $stable(restoreStatus)));

  assert_work_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    restoreWork |=> restoreWValid);

  assert_work_strobe_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !restoreWork |=> !restoreWValid);

  assert_loop_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    loopFinish |=> restoreLoopValid);

  assert_loop_strobe_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !loopFinish |=> !restoreLoopValid);

endmodule

bind shadow_bank shadow_bank_checker #(
  .DATA_W    (DATA_W),
  .NUM_W     (NUM_W),
  .STAT_W    (STAT_W),
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .FLAG_MASK (FLAG_MASK)
) u_checker (
  .clk              (clk),
  .rstN             (rstN),
  .saveWork         (saveWork),
  .restoreWork      (restoreWork),
  .loopBegin        (loopBegin),
  .loopFinish       (loopFinish),
  .hostW            (hostW),
  .hostStatus       (hostStatus),
  .hostLoopStart    (hostLoopStart),
  .hostLoopEnd      (hostLoopEnd),
  .hostLoopCount    (hostLoopCount),
  .restoreW         (restoreW),
  .restoreStatus    (restoreStatus),
  .restoreWValid    (restoreWValid),
  .restoreLoopStart (restoreLoopStart),
  .restoreLoopEnd   (restoreLoopEnd),
  .restoreLoopCount (restoreLoopCount),
  .restoreLoopValid (restoreLoopValid)
);

// File: tb/shadow_bank_bench.sv
module shadow_bank_bench;

  localparam logic [15:0] MASK = 16'h010F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        saveWork = 1'b0, restoreWork = 1'b0, loopBegin = 1'b0, loopFinish = 1'b0;
  logic [63:0] hostW = '0;
  logic [15:0] hostStatus = '0;
  logic [23:0] hostLoopStart = '0, hostLoopEnd = '0;
  logic [13:0] hostLoopCount = '0;
  logic [63:0] restoreW;
  logic [15:0] restoreStatus;
  logic        restoreWValid, restoreLoopValid;
  logic [23:0] restoreLoopStart, restoreLoopEnd;
  logic [13:0] restoreLoopCount;

  always #2.5 clk = ~clk;

  shadow_bank u_shadow_bank (
    .clk(clk), .rstN(rstN),
    .saveWork(saveWork), .restoreWork(restoreWork),
    .loopBegin(loopBegin), .loopFinish(loopFinish),
    .hostW(hostW), .hostStatus(hostStatus),
    .hostLoopStart(hostLoopStart), .hostLoopEnd(hostLoopEnd), .hostLoopCount(hostLoopCount),
    .restoreW(restoreW), .restoreStatus(restoreStatus), .restoreWValid(restoreWValid),
    .restoreLoopStart(restoreLoopStart), .restoreLoopEnd(restoreLoopEnd),
    .restoreLoopCount(restoreLoopCount), .restoreLoopValid(restoreLoopValid)
  );

  int checks = 0;
  int failures = 0;

  // bench model
  logic [63:0] mW = '0;
  logic [15:0] mFlags = '0;
  logic [23:0] mStart = '0, mEnd = '0;
  logic [13:0] mCount = '0;
  logic [63:0] eW = '0;
  logic [15:0] eStatus = '0;
  logic [23:0] eStart = '0, eEnd = '0;
  logic [13:0] eCount = '0;
  logic        eWV = 1'b0, eLV = 1'b0;

  function automatic logic [15:0] mergeStatus(input logic [15:0] live, input logic [15:0] saved);
    return (live & ~MASK) | (saved & MASK);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string wTag, input string lTag);
    check({wTag, " restoreWValid"}, 64'(restoreWValid), 64'(eWV));
    check({wTag, " restoreW"}, restoreW, eW);
    check({wTag, " restoreStatus"}, 64'(restoreStatus), 64'(eStatus));
    check({lTag, " restoreLoopValid"}, 64'(restoreLoopValid), 64'(eLV));
    check({lTag, " restoreLoopStart"}, 64'(restoreLoopStart), 64'(eStart));
    check({lTag, " restoreLoopEnd"}, 64'(restoreLoopEnd), 64'(eEnd));
    check({lTag, " restoreLoopCount"}, 64'(restoreLoopCount), 64'(eCount));
  endtask

  // one clock: drive at negedge, model update, check after the edge
  task automatic step(input logic sw, input logic rw, input logic lb, input logic lf,
                      input string wTag, input string lTag);
    @(negedge clk);
    saveWork = sw; restoreWork = rw; loopBegin = lb; loopFinish = lf;
    hostW = {$urandom, $urandom};
    hostStatus = 16'($urandom);
    hostLoopStart = 24'($urandom);
    hostLoopEnd = 24'($urandom);
    hostLoopCount = 14'($urandom);
    eWV = rw; eLV = lf;
    if (rw) begin eW = mW; eStatus = mergeStatus(hostStatus, mFlags); end
    if (lf) begin eStart = mStart; eEnd = mEnd; eCount = mCount; end
    if (sw) begin mW = hostW; mFlags = hostStatus & MASK; end
    if (lb) begin mStart = hostLoopStart; mEnd = hostLoopEnd; mCount = hostLoopCount; end
    @(posedge clk);
    #1;
    checkAll(wTag, lTag);
  endtask

  bit done = 1'b0;

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1", "R1");
    @(negedge clk);
    rstN = 1'b1;
    // R6: restore before any save
    step(0, 1, 0, 1, "R6", "R6");
    step(0, 0, 0, 0, "R8", "R8");
    // R2/R3 basic save then restore
    step(1, 0, 0, 0, "R2", "R2");
    step(0, 0, 0, 0, "R2", "R2");
    step(0, 1, 0, 0, "R3", "R7");
    // R8 back-to-back restores and hold
    step(0, 1, 0, 0, "R8", "R8");
    step(0, 0, 0, 0, "R8", "R8");
    // R5 double save
    step(1, 0, 0, 0, "R5", "R5");
    step(1, 0, 0, 0, "R5", "R5");
    step(0, 1, 0, 0, "R5", "R5");
    // R4 loop set
    step(0, 0, 1, 0, "R4", "R4");
    step(0, 0, 0, 1, "R4", "R4");
    // R5 loop overwrite
    step(0, 0, 1, 0, "R5", "R5");
    step(0, 0, 1, 0, "R5", "R5");
    step(0, 0, 0, 1, "R5", "R5");
    // R7 crossed same-cycle operations
    step(0, 1, 1, 0, "R7", "R7");
    step(1, 0, 0, 1, "R7", "R7");
    step(0, 1, 0, 1, "R7", "R7");
    step(1, 0, 1, 0, "R7", "R7");
    step(0, 1, 0, 1, "R7", "R7");
    // save immediately followed by restore
    step(1, 0, 1, 0, "R2", "R4");
    step(0, 1, 0, 1, "R2", "R4");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic sw, rw, lb, lf;
      sw = 1'($urandom); rw = 1'($urandom);
      lb = 1'($urandom); lf = 1'($urandom);
      if (sw) rw = 1'b0;
      if (lb) lf = 1'b0;
      step(sw, rw, lb, lf, "R7", "R7");
    end
    // mid-run reset clears outputs
    @(negedge clk);
    rstN = 1'b0; saveWork = 0; restoreWork = 0; loopBegin = 0; loopFinish = 0;
    @(posedge clk); #1;
    eW = '0; eStatus = '0; eStart = '0; eEnd = '0; eCount = '0; eWV = 0; eLV = 0;
    mW = '0; mFlags = '0; mStart = '0; mEnd = '0; mCount = '0;
    checkAll("R1", "R1");
    @(negedge clk);
    rstN = 1'b1;
    step(0, 1, 0, 1, "R6", "R6");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule